// File: doc/BRIEF.md
# Programmable Two-Stage Sinc Decimation Filter

This block turns a one-bit delta-sigma modulator stream into signed 24-bit samples. Each enabled modulator bit counts as +1 (bit high) or -1 (bit low). The bits pass through a third-order cascaded integrator-comb stage. A first-order averaging stage then accumulates several of those results. A 3-bit code selects the total oversampling ratio, from 32 up to 4096. The third-order stage decimates by the ratio up to a ceiling of 512. The averaging stage covers whatever factor remains.

The accumulated result is scaled so that a stream held at one level maps to the 24-bit full-scale value. Results above full scale are clamped. A resolution input can reduce each sample to its upper 16 bits. A single-cycle strobe marks each new sample and can drive a data-ready pin directly. After reset, or after the code changes, the chain restarts from cleared state. The first three results after a restart are dropped so that only settled samples are announced.

Top module: `sinc_decimator`

## Requirements
- R1: While reset is low, and after it is released with no enabled samples, `sample` reads 0 and `dataValid` reads 0.
- R2: Code c (0 to 7) selects an oversampling ratio OSR = 32·2^c. After a restart, `dataValid` rises in the cycle that follows the clock edge taking enabled sample number 4·OSR. It then rises again every OSR enabled samples.
- R3: A change of `osrCode` clears all filter state. The sample offered in the cycle of the change is dropped. The next three results are discarded, and the output due in that cycle is not announced.
- R4: An enabled bit of 1 counts as +1 and an enabled bit of 0 counts as -1. Bits offered while `modEn` is low have no effect on the value or on the timing of outputs.
- R5: Codes 5 to 7 decimate by 512 in the third-order stage and average 2, 4 or 8 of its results. A settled periodic input still gives the exact scaled mean.
- R6: For a settled input whose mean m over every OSR-sample window is constant, `sample` equals m·2^23 in two's complement (for example, m = +0.5 gives 0x400000 and m = -1 gives 0x800000).
- R7: A result above +2^23-1 is clamped to 0x7FFFFF. A constant high input therefore reads 0x7FFFFF.
- R8: With `res16` high, bits 7:0 of the announced sample are zero and bits 23:8 equal the 24-bit result.
- R9: `dataValid` is high for one cycle only, and `sample` holds its value until the next announced output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modEn | input | 1 | Modulator sample enable; one bit is taken per cycle in which it is high |
| modBit | input | 1 | Modulator bit (1 = +1, 0 = -1) |
| osrCode | input | 3 | Oversampling ratio code, OSR = 32·2^code |
| res16 | input | 1 | High to truncate the output to its upper 16 bits |
| sample | output | 24 | Signed decimated sample |
| dataValid | output | 1 | One-cycle strobe marking a new sample |

## Verification
A restart from a code change and the publication of a settled output can land on the same clock edge. In that case the restart must win. The bench runs the smallest ratio until outputs are being announced. It then changes the code in exactly the cycle whose enabled sample would complete the next output period. It expects no strobe from that edge, no strobe during the next three periods of the new ratio, and the first strobe after 4·OSR further enabled samples, carrying the fresh input's value.

// File: rtl/decim_pkg.sv
package decim_pkg;

  typedef struct packed {
    logic clear;
    logic intEn;
    logic combEn;
    logic outEn;
    logic publish;
  } decStrobe_t;

  // log2 of the decimation done by the third-order stage
  function automatic int sinc3Log(input int code, input int minLog, input int maxLog3);
    int total;
    total = minLog + code;
    return (total > maxLog3) ? maxLog3 : total;
  endfunction

  // log2 of the averaging length of the first-order stage
  function automatic int sinc1Log(input int code, input int minLog, input int maxLog3);
    return minLog + code - sinc3Log(code, minLog, maxLog3);
  endfunction

endpackage

// File: rtl/decim_ctrl.sv
module decim_ctrl
  import decim_pkg::*;
#(
  parameter int OSR_W         = 3,
  parameter int MIN_LOG       = 5,
  parameter int SINC3_MAX_LOG = 9,
  parameter int SINC1_MAX_LOG = 3,
  parameter int DISCARD       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modEn,
  input  logic [OSR_W-1:0] osrCode,
  output logic [OSR_W-1:0] activeCode,
  output decStrobe_t       strobe,
  output logic             dataValid
);

  localparam int DEC_W = SINC3_MAX_LOG;
  localparam int AVG_W = (SINC1_MAX_LOG > 0) ? SINC1_MAX_LOG : 1;
  localparam int DIS_W = $clog2(DISCARD + 1);

  logic [DEC_W-1:0] decCnt, decLim;
  logic [AVG_W-1:0] avgCnt, avgLim;
  logic [DIS_W-1:0] discardCnt;
  logic clearReq, decLast, avgLast, settled;
  int k3, k1;

  always_comb begin
    k3 = sinc3Log(int'(activeCode), MIN_LOG, SINC3_MAX_LOG);
    k1 = sinc1Log(int'(activeCode), MIN_LOG, SINC3_MAX_LOG);
    decLim = DEC_W'((1 << k3) - 1);
    avgLim = AVG_W'((1 << k1) - 1);
    clearReq = (osrCode != activeCode);
    decLast = (decCnt == decLim);
    avgLast = (avgCnt == avgLim);
    settled = (discardCnt == DIS_W'(DISCARD));
    strobe.clear   = clearReq;
    strobe.intEn   = modEn & ~clearReq;
    strobe.combEn  = strobe.intEn & decLast;
    strobe.outEn   = strobe.combEn & avgLast;
    strobe.publish = strobe.outEn & settled;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeCode <= '0;
      decCnt     <= '0;
      avgCnt     <= '0;
      discardCnt <= '0;
      dataValid  <= 1'b0;
    end else if (clearReq) begin
      activeCode <= osrCode;
      decCnt     <= '0;
      avgCnt     <= '0;
      discardCnt <= '0;
      dataValid  <= 1'b0;
    end else begin
      dataValid <= strobe.publish;
      if (strobe.intEn) decCnt <= decLast ? '0 : decCnt + 1'b1;
      if (strobe.combEn) avgCnt <= avgLast ? '0 : avgCnt + 1'b1;
      if (strobe.outEn && !settled) discardCnt <= discardCnt + 1'b1;
    end
  end

  // R9: the strobe never lasts two cycles
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  // R3: a pending restart never lets a strobe out
  assert_restart_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (osrCode != activeCode) |=> !dataValid);

  // R4: a strobe always follows an enabled modulator sample
  assert_valid_after_sample_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> $past(modEn));

  // R2: the decimation counter stays inside the selected ratio
  assert_dec_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    decCnt <= decLim);

endmodule

// File: rtl/decim_datapath.sv
module decim_datapath
  import decim_pkg::*;
#(
  parameter int OSR_W         = 3,
  parameter int MIN_LOG       = 5,
  parameter int SINC3_MAX_LOG = 9,
  parameter int SINC1_MAX_LOG = 3,
  parameter int ORDER         = 3,
  parameter int SAMPLE_W      = 24,
  parameter int TRUNC_W       = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modBit,
  input  logic                res16,
  input  logic [OSR_W-1:0]    activeCode,
  input  decStrobe_t          strobe,
  output logic [SAMPLE_W-1:0] sampleOut
);

  localparam int INT_W  = ORDER * SINC3_MAX_LOG + 2;
  localparam int ACC_W  = INT_W + SINC1_MAX_LOG;
  localparam int PRE    = SAMPLE_W - 1 - ORDER * MIN_LOG;
  localparam int WIDE_W = ACC_W + PRE;
  localparam int DROP_W = SAMPLE_W - TRUNC_W;
  localparam logic signed [WIDE_W-1:0] MAXV = WIDE_W'((64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1);
  localparam logic signed [WIDE_W-1:0] MINV = -MAXV - WIDE_W'(1);

  logic signed [INT_W-1:0] intQ [ORDER];
  logic signed [INT_W-1:0] intD [ORDER];
  logic signed [INT_W-1:0] combQ [ORDER];
  logic signed [INT_W-1:0] combD [ORDER+1];
  logic signed [INT_W-1:0] inVal, combOut, combLim;
  logic signed [ACC_W-1:0] accQ, accSum;
  logic signed [WIDE_W-1:0] wide;
  logic [SAMPLE_W-1:0] satVal, shaped;
  int k3, k1, rsh;

  always_comb begin
    inVal = modBit ? INT_W'(1) : -INT_W'(1);
    intD[0] = intQ[0] + inVal;
    for (int s = 1; s < ORDER; s++) intD[s] = intQ[s] + intD[s-1];
    combD[0] = intD[ORDER-1];
    for (int s = 0; s < ORDER; s++) combD[s+1] = combD[s] - combQ[s];
    combOut = combD[ORDER];
  end

  generate
    for (genvar s = 0; s < ORDER; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          intQ[s]  <= '0;
          combQ[s] <= '0;
        end else if (strobe.clear) begin
          intQ[s]  <= '0;
          combQ[s] <= '0;
        end else begin
          if (strobe.intEn)  intQ[s]  <= intD[s];
          if (strobe.combEn) combQ[s] <= combD[s];
        end
      end
    end
  endgenerate

  always_comb begin
    k3 = sinc3Log(int'(activeCode), MIN_LOG, SINC3_MAX_LOG);
    k1 = sinc1Log(int'(activeCode), MIN_LOG, SINC3_MAX_LOG);
    rsh = ORDER * (k3 - MIN_LOG) + k1;
    combLim = INT_W'(1) <<< (ORDER * k3);
    accSum = accQ + ACC_W'(combOut);
    wide = (WIDE_W'(accSum) <<< PRE) >>> rsh;
    if (wide > MAXV)      satVal = MAXV[SAMPLE_W-1:0];
    else if (wide < MINV) satVal = MINV[SAMPLE_W-1:0];
    else                  satVal = wide[SAMPLE_W-1:0];
    shaped = res16 ? {satVal[SAMPLE_W-1:DROP_W], DROP_W'(0)} : satVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ      <= '0;
      sampleOut <= '0;
    end else if (strobe.clear) begin
      accQ <= '0;
    end else begin
      if (strobe.combEn) accQ <= strobe.outEn ? '0 : accSum;
      if (strobe.publish) sampleOut <= shaped;
    end
  end

  // R5: each third-order result stays within the gain of the active ratio
  assert_cic_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.combEn |-> (combOut <= combLim) && (combOut >= -combLim));

  // R8: a short-format sample carries no low-order bits
  assert_trunc_low_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.publish && res16) |=> (sampleOut[DROP_W-1:0] == '0));

endmodule

// File: rtl/sinc_decimator.sv
module sinc_decimator
  import decim_pkg::*;
#(
  parameter int OSR_W         = 3,
  parameter int MIN_LOG       = 5,
  parameter int SINC3_MAX_LOG = 9,
  parameter int SAMPLE_W      = 24,
  parameter int TRUNC_W       = 16,
  parameter int DISCARD       = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modEn,
  input  logic                modBit,
  input  logic [OSR_W-1:0]    osrCode,
  input  logic                res16,
  output logic [SAMPLE_W-1:0] sample,
  output logic                dataValid
);

  localparam int MAX_LOG       = MIN_LOG + (1 << OSR_W) - 1;
  localparam int SINC1_MAX_LOG = MAX_LOG - SINC3_MAX_LOG;

  decStrobe_t strobe;
  logic [OSR_W-1:0] activeCode;

  decim_ctrl #(
    .OSR_W(OSR_W), .MIN_LOG(MIN_LOG), .SINC3_MAX_LOG(SINC3_MAX_LOG),
    .SINC1_MAX_LOG(SINC1_MAX_LOG), .DISCARD(DISCARD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modEn(modEn), .osrCode(osrCode),
    .activeCode(activeCode), .strobe(strobe), .dataValid(dataValid)
  );

  decim_datapath #(
    .OSR_W(OSR_W), .MIN_LOG(MIN_LOG), .SINC3_MAX_LOG(SINC3_MAX_LOG),
    .SINC1_MAX_LOG(SINC1_MAX_LOG), .ORDER(3), .SAMPLE_W(SAMPLE_W), .TRUNC_W(TRUNC_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .modBit(modBit), .res16(res16),
    .activeCode(activeCode), .strobe(strobe), .sampleOut(sample)
  );

endmodule

// File: tb/sinc_decimator_test.sv
module sinc_decimator_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modEn = 1'b0;
  logic modBit = 1'b0;
  logic [2:0] osrCode = 3'd0;
  logic res16 = 1'b0;
  logic [23:0] sample;
  logic dataValid;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sinc_decimator uut (
    .clk(clk), .rstN(rstN), .modEn(modEn), .modBit(modBit),
    .osrCode(osrCode), .res16(res16), .sample(sample), .dataValid(dataValid)
  );

  // pattern codes: 0 all ones, 1 all zeros, 2 = 1110, 3 = 1000, 4 = 10
  typedef struct packed {
    logic [2:0]  code;
    logic [2:0]  pat;
    logic        res;
    logic [23:0] expv;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{3'd0, 3'd0, 1'b0, 24'h7FFFFF, 4'd7},  // R7 clamp
    '{3'd1, 3'd1, 1'b0, 24'h800000, 4'd6},  // R6 negative full scale
    '{3'd2, 3'd2, 1'b0, 24'h400000, 4'd6},  // R6 half scale
    '{3'd3, 3'd3, 1'b0, 24'hC00000, 4'd6},  // R6 minus half
    '{3'd4, 3'd4, 1'b0, 24'h000000, 4'd6},  // R6 zero mean
    '{3'd5, 3'd2, 1'b0, 24'h400000, 4'd5},  // R5 averaging by 2
    '{3'd6, 3'd3, 1'b0, 24'hC00000, 4'd5},  // R5 averaging by 4
    '{3'd7, 3'd0, 1'b1, 24'h7FFF00, 4'd8},  // R8 clamp then truncate
    '{3'd2, 3'd1, 1'b1, 24'h800000, 4'd8},  // R8
    '{3'd0, 3'd3, 1'b1, 24'hC00000, 4'd8}   // R8
  };

  function automatic logic patBit(input logic [2:0] pat, input int idx);
    case (pat)
      3'd0: return 1'b1;
      3'd1: return 1'b0;
      3'd2: return (idx % 4) != 3;
      3'd3: return (idx % 4) == 0;
      default: return (idx % 2) == 0;
    endcase
  endfunction

  task automatic expectEq(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idleCycle(input logic [2:0] code, input logic res);
    @(negedge clk);
    osrCode = code;
    res16 = res;
    modEn = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic runRow(input vec_t vc);
    int osr, firstIdx, secondIdx;
    logic [23:0] firstVal, secondVal, midVal;
    string tag;
    osr = 32 << vc.code;
    tag = $sformatf("R%0d", vc.req);
    firstIdx = -1;
    secondIdx = -1;
    firstVal = '0;
    secondVal = '0;
    midVal = '0;
    idleCycle(vc.code, vc.res);
    for (int k = 1; k <= 5 * osr; k++) begin
      @(negedge clk);
      modEn = 1'b1;
      modBit = patBit(vc.pat, k - 1);
      @(posedge clk);
      #1;
      if (dataValid) begin
        if (firstIdx < 0) begin
          firstIdx = k;
          firstVal = sample;
        end else if (secondIdx < 0) begin
          secondIdx = k;
          secondVal = sample;
        end
      end
      if (k == 4 * osr + osr / 2) midVal = sample;
    end
    @(negedge clk);
    modEn = 1'b0;
    expectEq("R2", "first strobe index", firstIdx, 4 * osr);
    expectEq("R2", "second strobe index", secondIdx, 5 * osr);
    expectEq(tag, "first value", firstVal, vc.expv);
    expectEq(tag, "second value", secondVal, vc.expv);
    expectEq("R9", "held value between strobes", midVal, vc.expv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int first, idleValids, earlyValids;
    logic [23:0] val;
    logic sawAt128;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    expectEq("R1", "sample in reset", sample, 0);
    expectEq("R1", "dataValid in reset", dataValid, 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    expectEq("R1", "sample after release", sample, 0);
    expectEq("R1", "dataValid after release", dataValid, 0);

    for (int v = 0; v < 10; v++) runRow(VECS[v]);

    // R4: bits offered while modEn is low are ignored
    idleCycle(3'd1, 1'b0);
    first = -1;
    idleValids = 0;
    val = '0;
    for (int e = 1; e <= 256; e++) begin
      @(negedge clk);
      modEn = 1'b1;
      modBit = patBit(3'd2, e - 1);
      @(posedge clk);
      #1;
      if (dataValid && first < 0) begin
        first = e;
        val = sample;
      end
      @(negedge clk);
      modEn = 1'b0;
      modBit = ~patBit(3'd2, e - 1);
      @(posedge clk);
      #1;
      if (dataValid) idleValids++;
    end
    expectEq("R4", "strobe index with gaps", first, 256);
    expectEq("R4", "value with gaps", val, 24'h400000);
    expectEq("R4", "strobes on idle cycles", idleValids, 0);

    // R3: code change on the edge that would publish
    idleCycle(3'd0, 1'b0);
    sawAt128 = 1'b0;
    for (int k = 1; k <= 159; k++) begin
      @(negedge clk);
      modEn = 1'b1;
      modBit = 1'b1;
      @(posedge clk);
      #1;
      if (k == 128) sawAt128 = dataValid;
    end
    expectEq("R2", "strobe before restart", sawAt128, 1);
    @(negedge clk);
    osrCode = 3'd1;
    modEn = 1'b1;
    modBit = 1'b1;
    @(posedge clk);
    #1;
    expectEq("R3", "strobe on restart edge", dataValid, 0);
    first = -1;
    earlyValids = 0;
    val = '0;
    for (int j = 1; j <= 256; j++) begin
      @(negedge clk);
      modEn = 1'b1;
      modBit = 1'b0;
      @(posedge clk);
      #1;
      if (dataValid) begin
        if (j < 256) earlyValids++;
        if (first < 0) begin
          first = j;
          val = sample;
        end
      end
    end
    expectEq("R3", "strobes during discard", earlyValids, 0);
    expectEq("R3", "first strobe after restart", first, 256);
    expectEq("R3", "value after restart", val, 24'h800000);

    // R1: reset in the middle of a run
    @(negedge clk);
    rstN = 1'b0;
    modEn = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    expectEq("R1", "sample after mid-run reset", sample, 0);
    expectEq("R1", "dataValid after mid-run reset", dataValid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule